// File: doc/BRIEF.md
# Load/Store Translator Selector Bank

This block keeps the translator configuration for up to 64 general registers. Each register owns two 4-bit codes: one chosen when the register is the destination of a load, one chosen when it is the source of a store. Code 0 means identity. Sixteen codes share one 64-bit control register, so four registers hold all the load-side codes and four hold the store-side codes.

Software reaches the bank through a single-cycle CSR port. It carries an address, an operation (read, write, set bits, clear bits) and write data. It returns the old register contents and an illegal-access flag in the same cycle. The load/store pipeline reads the bank through two combinational lookup ports. One takes a load destination index and one takes a store source index, and each returns the code to apply. A read-only capability register reports the version, the set of implemented translator codes and whether the upper register groups exist. A parameter decides whether the bank covers all 64 registers or only registers 0 to 31.

Top module: `xcfg_bank`

## Requirements
- R1: The load-code registers sit at CSR addresses 0x800+g and the store-code registers at 0x804+g, for g = 0..3. Register g covers general registers 16g..16g+15. Bits [4i+3:4i] hold the code of register 16g+i, so the load code of register 5 is bits [23:20] of 0x800.
- R2: With HAS_UPPER = 0, addresses 0x802, 0x803, 0x806 and 0x807 are illegal, return zero read data and change no state. In that case the lookup ports return 0 for registers 32..63.
- R3: Reset (rst_ni low) clears all eight code registers to zero, so every lookup returns 0.
- R4: The fields of register 0 store and read back like any other field, but both lookup ports return 0 for index 0 whatever those fields hold.
- R5: A read of address 0xFC4 is legal and returns the capability word: bit 0 = 1, bits [7:1] = 1, bits [19:8] = SLOTS_IMPL (bit i-1 for code i, default 0x7FF), bit 20 = HAS_UPPER, all other bits zero. With the default parameters this is 0x17FF03.
- R6: Any write, set or clear to 0xFC4 raises the illegal flag and changes no state.
- R7: Operation codes are 00 read, 01 write, 10 set bits (OR), 11 clear bits (AND NOT). Every legal access returns the pre-update contents on csr_rdata_o, and the new value takes effect at the next rising clock edge.
- R8: The lookup ports are combinational in the index. During the cycle of a write they show the old code, and from the cycle after it they show the new code.
- R9: Any address outside 0x800..0x807 and 0xFC4 is illegal, returns zero read data and changes no state.
- R10: csr_illegal_o is low whenever csr_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_valid_i | input | 1 | CSR access strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_wdata_i | input | 64 | Write data or bit mask |
| csr_rdata_o | output | 64 | Pre-update register contents |
| csr_illegal_o | output | 1 | Access to an absent or read-only register |
| ld_idx_i | input | 6 | Load destination register index |
| ld_code_o | output | 4 | Load translator code for ld_idx_i |
| st_idx_i | input | 6 | Store source register index |
| st_code_o | output | 4 | Store translator code for st_idx_i |

## Verification
The tests use several write patterns. A pattern whose every field holds its own index shows that field positions and group bases are not shifted or swapped. A pattern with a non-zero register-0 field separates the register 0 override from plain storage. Write, set and clear run in sequence on overlapping masks, so each operation is told apart from the others and the returned old value is told apart from the new one. Full and reduced configurations receive the same access stream, so the upper-group gating, the capability word and the illegal-address handling are compared side by side.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  localparam int          ADDR_W    = 12;
  localparam logic [11:0] BANK_BASE = 12'h800;
  localparam logic [11:0] FEAT_ADDR = 12'hFC4;
  localparam logic [6:0]  VERSION   = 7'd1;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;
endpackage

// File: rtl/xcfg_decode.sv
module xcfg_decode
  import xcfg_pkg::*;
#(
  parameter int MAX_GROUPS  = 4,
  parameter int IMPL_GROUPS = 4
) (
  input  logic                  valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  csr_op_e               op_i,
  output logic [MAX_GROUPS-1:0] rd_sel_o,
  output logic [MAX_GROUPS-1:0] wr_sel_o,
  output logic                  feat_sel_o,
  output logic                  modify_o,
  output logic                  illegal_o
);
  logic [MAX_GROUPS-1:0] rd_hit, wr_hit;
  logic                  feat_hit, known, ok;

  always_comb begin
    rd_hit = '0;
    wr_hit = '0;
    for (int g = 0; g < MAX_GROUPS; g++) begin
      if (g < IMPL_GROUPS) begin
        rd_hit[g] = (addr_i == BANK_BASE + ADDR_W'(g));
        wr_hit[g] = (addr_i == BANK_BASE + ADDR_W'(MAX_GROUPS + g));
      end
    end
    feat_hit   = (addr_i == FEAT_ADDR);
    modify_o   = (op_i != OP_READ);
    known      = (|rd_hit) | (|wr_hit) | feat_hit;
    illegal_o  = valid_i & (~known | (feat_hit & modify_o));
    ok         = valid_i & ~illegal_o;
    rd_sel_o   = ok ? rd_hit : '0;
    wr_sel_o   = ok ? wr_hit : '0;
    feat_sel_o = ok & feat_hit;
  end
endmodule

// File: rtl/xcfg_csr_reg.sv
module xcfg_csr_reg
  import xcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_WRITE: nxt = wdata_i;
      OP_SET:   nxt = q_o | wdata_i;
      OP_CLEAR: nxt = q_o & ~wdata_i;
      default:  nxt = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= nxt;
  end
endmodule

// File: rtl/xcfg_lookup.sv
module xcfg_lookup #(
  parameter int XLEN        = 64,
  parameter int CODE_W      = 4,
  parameter int MAX_GROUPS  = 4,
  parameter int IMPL_GROUPS = 4,
  parameter int IDX_W       = 6
) (
  input  logic [MAX_GROUPS-1:0][XLEN-1:0] bank_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [CODE_W-1:0]               code_o
);
  localparam int FIELDS = XLEN / CODE_W;
  localparam int FLD_W  = $clog2(FIELDS);
  localparam int GRP_W  = IDX_W - FLD_W;

  logic [GRP_W-1:0]                grp;
  logic [FLD_W-1:0]                fld;
  logic [FIELDS-1:0][CODE_W-1:0]   fields;

  always_comb begin
    grp    = idx_i[IDX_W-1:FLD_W];
    fld    = idx_i[FLD_W-1:0];
    fields = bank_i[grp];
    code_o = fields[fld];
    // register 0 always translates as identity; absent groups likewise
    if (idx_i == '0 || int'(grp) >= IMPL_GROUPS) code_o = '0;
  end
endmodule

// File: rtl/xcfg_bank.sv
module xcfg_bank
  import xcfg_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          CODE_W     = 4,
  parameter int          NUM_REGS   = 64,
  parameter bit          HAS_UPPER  = 1'b1,
  parameter logic [11:0] SLOTS_IMPL = 12'h7FF,
  localparam int         IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_valid_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  input  logic [IDX_W-1:0]  ld_idx_i,
  output logic [CODE_W-1:0] ld_code_o,
  input  logic [IDX_W-1:0]  st_idx_i,
  output logic [CODE_W-1:0] st_code_o
);
  localparam int GROUP_REGS  = XLEN / CODE_W;
  localparam int MAX_GROUPS  = NUM_REGS / GROUP_REGS;
  localparam int IMPL_GROUPS = HAS_UPPER ? MAX_GROUPS : MAX_GROUPS / 2;
  localparam logic [XLEN-1:0] FEAT_VAL =
    XLEN'({HAS_UPPER, SLOTS_IMPL, VERSION, 1'b1});

  csr_op_e                         op;
  logic [MAX_GROUPS-1:0]           rd_sel, wr_sel;
  logic                            feat_sel, modify;
  logic [MAX_GROUPS-1:0][XLEN-1:0] rd_q, wr_q;

  assign op = csr_op_e'(csr_op_i);

  xcfg_decode #(
    .MAX_GROUPS (MAX_GROUPS),
    .IMPL_GROUPS(IMPL_GROUPS)
  ) u_decode (
    .valid_i   (csr_valid_i),
    .addr_i    (csr_addr_i),
    .op_i      (op),
    .rd_sel_o  (rd_sel),
    .wr_sel_o  (wr_sel),
    .feat_sel_o(feat_sel),
    .modify_o  (modify),
    .illegal_o (csr_illegal_o)
  );

  for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_grp
    if (g < IMPL_GROUPS) begin : g_impl
      xcfg_csr_reg #(.XLEN(XLEN)) u_rd (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (rd_sel[g] & modify),
        .op_i   (op),
        .wdata_i(csr_wdata_i),
        .q_o    (rd_q[g])
      );
      xcfg_csr_reg #(.XLEN(XLEN)) u_wr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_sel[g] & modify),
        .op_i   (op),
        .wdata_i(csr_wdata_i),
        .q_o    (wr_q[g])
      );
    end else begin : g_absent
      assign rd_q[g] = '0;
      assign wr_q[g] = '0;
    end
  end

  always_comb begin
    csr_rdata_o = feat_sel ? FEAT_VAL : '0;
    for (int g = 0; g < MAX_GROUPS; g++) begin
      if (rd_sel[g]) csr_rdata_o |= rd_q[g];
      if (wr_sel[g]) csr_rdata_o |= wr_q[g];
    end
  end

  xcfg_lookup #(
    .XLEN(XLEN), .CODE_W(CODE_W), .MAX_GROUPS(MAX_GROUPS),
    .IMPL_GROUPS(IMPL_GROUPS), .IDX_W(IDX_W)
  ) u_ld_lookup (
    .bank_i(rd_q),
    .idx_i (ld_idx_i),
    .code_o(ld_code_o)
  );

  xcfg_lookup #(
    .XLEN(XLEN), .CODE_W(CODE_W), .MAX_GROUPS(MAX_GROUPS),
    .IMPL_GROUPS(IMPL_GROUPS), .IDX_W(IDX_W)
  ) u_st_lookup (
    .bank_i(wr_q),
    .idx_i (st_idx_i),
    .code_o(st_code_o)
  );
endmodule

// File: rtl/xcfg_bank_chk.sv
module xcfg_bank_chk #(
  parameter int          XLEN       = 64,
  parameter int          CODE_W     = 4,
  parameter int          IDX_W      = 6,
  parameter bit          HAS_UPPER  = 1'b1,
  parameter logic [11:0] SLOTS_IMPL = 12'h7FF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_valid_i,
  input logic [11:0]       csr_addr_i,
  input logic [1:0]        csr_op_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_illegal_o,
  input logic [IDX_W-1:0]  ld_idx_i,
  input logic [CODE_W-1:0] ld_code_o,
  input logic [IDX_W-1:0]  st_idx_i,
  input logic [CODE_W-1:0] st_code_o
);
  logic feat_acc, bank_acc, upper_acc, wr0;

  assign feat_acc  = csr_valid_i && csr_addr_i == 12'hFC4;
  assign bank_acc  = csr_addr_i >= 12'h800 && csr_addr_i <= 12'h807;
  assign upper_acc = csr_valid_i && bank_acc && csr_addr_i[1];
  assign wr0       = csr_valid_i && csr_addr_i == 12'h800 && csr_op_i == 2'b01;

  assert_x0_identity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_idx_i == '0 |-> ld_code_o == '0) and (st_idx_i == '0 |-> st_code_o == '0));

  assert_feat_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_acc && csr_op_i == 2'b00 |->
      !csr_illegal_o && csr_rdata_o == XLEN'({HAS_UPPER, SLOTS_IMPL, 7'd1, 1'b1}));

  assert_feat_readonly_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_acc && csr_op_i != 2'b00 |-> csr_illegal_o);

  assert_write_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> ((csr_valid_i && csr_addr_i == 12'h800 && csr_op_i == 2'b00)
             ? csr_rdata_o == $past(csr_wdata_i) : 1'b1));

  assert_lookup_next_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> (ld_idx_i == IDX_W'(5) ? ld_code_o == $past(csr_wdata_i[23:20]) : 1'b1));

  assert_unknown_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_valid_i && !bank_acc && csr_addr_i != 12'hFC4 |-> csr_illegal_o && csr_rdata_o == '0);

  assert_idle_no_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |-> !csr_illegal_o);

  assert_upper_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_UPPER && upper_acc |-> csr_illegal_o && csr_rdata_o == '0);
endmodule

bind xcfg_bank xcfg_bank_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .IDX_W(IDX_W),
  .HAS_UPPER(HAS_UPPER), .SLOTS_IMPL(SLOTS_IMPL)
) u_chk (.*);

// File: tb/xcfg_bank_tb.sv
module xcfg_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [11:0] addr;
  logic [1:0]  op;
  logic [63:0] wdata;
  logic [5:0]  ld_idx, st_idx;

  logic [63:0] rd_w, rd_n;
  logic        ill_w, ill_n;
  logic [3:0]  ldc_w, stc_w, ldc_n, stc_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] PAT0 = 64'hFEDC_BA98_7654_321F;

  always #2.5 clk = ~clk;

  xcfg_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(valid), .csr_addr_i(addr),
    .csr_op_i(op), .csr_wdata_i(wdata), .csr_rdata_o(rd_w), .csr_illegal_o(ill_w),
    .ld_idx_i(ld_idx), .ld_code_o(ldc_w), .st_idx_i(st_idx), .st_code_o(stc_w)
  );

  xcfg_bank #(.HAS_UPPER(1'b0)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(valid), .csr_addr_i(addr),
    .csr_op_i(op), .csr_wdata_i(wdata), .csr_rdata_o(rd_n), .csr_illegal_o(ill_n),
    .ld_idx_i(ld_idx), .ld_code_o(ldc_n), .st_idx_i(st_idx), .st_code_o(stc_n)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one access after a falling edge, sample its combinational
  // response, then let it commit at the rising edge
  logic [63:0] s_rd_w, s_rd_n;
  logic        s_ill_w, s_ill_n;
  task automatic access(logic [1:0] o, logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    valid = 1'b1; op = o; addr = a; wdata = d;
    #1;
    s_rd_w = rd_w; s_ill_w = ill_w; s_rd_n = rd_n; s_ill_n = ill_n;
    @(posedge clk);
    #1;
    valid = 1'b0; op = 2'b00; wdata = '0;
  endtask

  task automatic look(logic [5:0] li, logic [5:0] si);
    ld_idx = li; st_idx = si;
    #1;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin
      access(2'b00, 12'h800 + 12'(a), '0);
      chk("R3 reset csr", s_rd_w, '0);
      chk("R1 legal addr", 64'(s_ill_w), 0);
    end
    look(6'd5, 6'd33);
    chk("R3 reset ld", 64'(ldc_w), 0);
    chk("R3 reset st", 64'(stc_w), 0);
  endtask

  task automatic t_map();
    access(2'b01, 12'h800, PAT0);
    look(6'd5, 6'd5);
    chk("R1 ld reg5", 64'(ldc_w), 5);
    chk("R1 st reg5 untouched", 64'(stc_w), 0);
    look(6'd15, 6'd0);
    chk("R1 ld reg15", 64'(ldc_w), 15);
    look(6'd0, 6'd0);
    chk("R4 ld reg0 identity", 64'(ldc_w), 0);
    access(2'b00, 12'h800, '0);
    chk("R4 reg0 field stored", s_rd_w, PAT0);
    access(2'b01, 12'h807, 64'h0123_4567_89AB_CDEF);
    chk("R2 narrow 0x807 illegal", 64'(s_ill_n), 1);
    look(6'd0, 6'd48);
    chk("R1 st reg48", 64'(stc_w), 4'hF);
    chk("R2 narrow st reg48", 64'(stc_n), 0);
    look(6'd48, 6'd52);
    chk("R1 st reg52", 64'(stc_w), 4'hB);
    chk("R1 ld reg48 untouched", 64'(ldc_w), 0);
    look(6'd0, 6'd63);
    chk("R1 st reg63", 64'(stc_w), 0);
  endtask

  task automatic t_ops();
    access(2'b01, 12'h805, 64'h0F0);
    chk("R7 write old", s_rd_w, 0);
    access(2'b10, 12'h805, 64'hF00);
    chk("R7 set old", s_rd_w, 64'h0F0);
    access(2'b00, 12'h805, '0);
    chk("R7 after set", s_rd_w, 64'hFF0);
    access(2'b11, 12'h805, 64'h0F0);
    chk("R7 clear old", s_rd_w, 64'hFF0);
    access(2'b00, 12'h805, '0);
    chk("R7 after clear", s_rd_w, 64'hF00);
    look(6'd0, 6'd18);
    chk("R7 st reg18", 64'(stc_w), 4'hF);
    look(6'd0, 6'd17);
    chk("R7 st reg17", 64'(stc_w), 0);
  endtask

  task automatic t_visibility();
    look(6'd0, 6'd1);
    @(negedge clk);
    valid = 1'b1; op = 2'b01; addr = 12'h804; wdata = 64'h50;
    #1;
    chk("R8 old code during write", 64'(stc_w), 0);
    @(posedge clk);
    #1;
    valid = 1'b0; op = 2'b00;
    chk("R8 new code after edge", 64'(stc_w), 5);
  endtask

  task automatic t_feature();
    access(2'b00, 12'hFC4, '0);
    chk("R5 feature wide", s_rd_w, 64'h17FF03);
    chk("R5 feature narrow", s_rd_n, 64'h07FF03);
    chk("R5 feature legal", 64'(s_ill_w), 0);
    access(2'b01, 12'hFC4, '1);
    chk("R6 write illegal", 64'(s_ill_w), 1);
    access(2'b11, 12'hFC4, '1);
    chk("R6 clear illegal", 64'(s_ill_n), 1);
    access(2'b00, 12'hFC4, '0);
    chk("R6 feature unchanged", s_rd_w, 64'h17FF03);
    access(2'b00, 12'h800, '0);
    chk("R6 bank unchanged", s_rd_w, PAT0);
  endtask

  task automatic t_narrow();
    access(2'b01, 12'h802, '1);
    chk("R2 wide 0x802 legal", 64'(s_ill_w), 0);
    chk("R2 narrow 0x802 illegal", 64'(s_ill_n), 1);
    access(2'b00, 12'h802, '0);
    chk("R2 narrow rdata zero", s_rd_n, 0);
    chk("R2 wide readback", s_rd_w, '1);
    look(6'd40, 6'd0);
    chk("R2 wide ld reg40", 64'(ldc_w), 4'hF);
    chk("R2 narrow ld reg40", 64'(ldc_n), 0);
    access(2'b00, 12'h803, '0);
    chk("R2 narrow 0x803 illegal", 64'(s_ill_n), 1);
  endtask

  task automatic t_unknown();
    access(2'b01, 12'h808, '1);
    chk("R9 0x808 illegal", 64'(s_ill_w), 1);
    chk("R9 0x808 rdata", s_rd_w, 0);
    access(2'b10, 12'h7FF, '1);
    chk("R9 0x7FF illegal", 64'(s_ill_n), 1);
    access(2'b00, 12'h800, '0);
    chk("R9 bank unchanged", s_rd_w, PAT0);
    @(negedge clk);
    valid = 1'b0; addr = 12'h808; op = 2'b01;
    #1;
    chk("R10 idle no flag", 64'(ill_w | ill_n), 0);
    op = 2'b00;
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    look(6'd5, 6'd18);
    chk("R3 async clear ld", 64'(ldc_w), 0);
    chk("R3 async clear st", 64'(stc_w), 0);
    @(negedge clk);
    rst_n = 1'b1;
    access(2'b00, 12'h800, '0);
    chk("R3 reset csr again", s_rd_w, 0);
  endtask

  initial begin
    rst_n = 1'b0; valid = 1'b0; addr = '0; op = 2'b00; wdata = '0;
    ld_idx = '0; st_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_ops();
    t_visibility();
    t_feature();
    t_narrow();
    t_unknown();
    t_rereset();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule